// File: doc/BRIEF.md
# Gated Adder/Subtractor

A purely combinational two's-complement adder/subtractor, four bits wide by default. The second operand does not go straight to the adder. It passes through AND-OR gating that two independent control lines steer. One line lets the true operand bits through. The other lets the inverted bits through and also forces the carry into the least significant stage. The gated operand and the first operand then feed a ripple-carry chain of full adders. Each full adder is built from two half adders and an OR gate.

With only the add line high, the block returns A plus B. With only the subtract line high, it returns A minus B, because the inverted operand plus the forced carry is the two's complement of B. The most significant result bit is the sign. The raw carry out of the top stage is reported but plays no part in the signed result. A separate overflow flag reports when the signed result does not fit in the width.

Both control lines are defined in every combination. With both low, the gated operand is all zeros and the result is A. With both high, the gated operand is all ones and the carry-in is 1, so the result is again A, with the carry out set. The block has no clock, no state and no handshake. It is meant to sit inside a datapath stage whose registers surround it.

Top module: `gated_addsub`

## Requirements
- R1: With add_sel=1 and sub_sel=0, sum_out equals (op_a + op_b) modulo 16, and carry_out is bit 4 of the 5-bit unsigned sum.
- R2: With add_sel=0 and sub_sel=1, sum_out equals (op_a - op_b) modulo 16, and carry_out is 1 exactly when op_a >= op_b as unsigned values.
- R3: ovf_out is 1 exactly when the signed result of the operation performed (in the range -8..7 for 4-bit operands) is out of range. It is 0 in the idle and both-high cases.
- R4: With add_sel=0 and sub_sel=0, sum_out equals op_a, carry_out is 0 and ovf_out is 0.
- R5: With add_sel=1 and sub_sel=1, sum_out equals op_a, carry_out is 1 and ovf_out is 0.
- R6: Subtracting 0110 from 0100 gives sum_out 1110 (-2), carry_out 0 and ovf_out 0.
- R7: Adding 1101 (-3) and 0110 (+6) gives sum_out 0011 (+3), carry_out 1 and ovf_out 0.
- R8: In subtract mode without overflow, sum_out[3] (the sign bit) is 1 exactly when op_a < op_b as signed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand (minuend in subtract mode) |
| op_b | input | 4 | Second operand, passed through the gating |
| add_sel | input | 1 | Passes the true op_b bits to the adder |
| sub_sel | input | 1 | Passes the inverted op_b bits and forces the carry-in to 1 |
| sum_out | output | 4 | Result, two's complement, MSB is the sign |
| carry_out | output | 1 | Raw carry out of the top stage |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
Random operand pairs are applied under all four settings of the two control lines. Addition and subtraction are compared separately, so a swapped gating term or a carry-in tied to the wrong line shows up in one mode and not the other. The idle and both-high settings tell apart a gate that merges B with not-B correctly from one that lets a single polarity leak through. Directed pairs at the signed extremes (-8, +7, 0 and -1) separate the true overflow rule from a check on the carry out alone, and the two worked cases pin down the sign bit and the ignored carry.

// File: rtl/gated_addsub_pkg.sv
package gated_addsub_pkg;
  // Mode word formed as {add_sel, sub_sel}
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_SUB  = 2'b01,
    MODE_ADD  = 2'b10,
    MODE_BOTH = 2'b11
  } mode_e;
endpackage

// File: rtl/addsub_half_adder.sv
module addsub_half_adder (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/addsub_full_adder.sv
module addsub_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic s_first, c_first, c_second;

  addsub_half_adder u_ha_lo (.x_i(x_i),     .y_i(y_i),  .s_o(s_first), .c_o(c_first));
  addsub_half_adder u_ha_hi (.x_i(s_first), .y_i(ci_i), .s_o(s_o),     .c_o(c_second));

  assign co_o = c_first | c_second;

  always_comb begin
    AST_FA_COUNT: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {1'b0, ci_i})); // R1
  end
endmodule

// File: rtl/addsub_operand_gate.sv
module addsub_operand_gate #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             pass_true_i,
  input  logic             pass_inv_i,
  output logic [WIDTH-1:0] b_o,
  output logic             cin_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic true_leg, inv_leg;
    assign true_leg = b_i[i] & pass_true_i;
    assign inv_leg  = ~b_i[i] & pass_inv_i;
    assign b_o[i]   = true_leg | inv_leg;
  end

  assign cin_o = pass_inv_i;

  always_comb begin
    if (!pass_true_i && !pass_inv_i) AST_GATE_IDLE_ZERO: assert (b_o == '0);  // R4
    if (pass_true_i && pass_inv_i)   AST_GATE_BOTH_ONES: assert (&b_o);       // R5
    if (pass_inv_i && !pass_true_i)  AST_GATE_INVERTS:   assert ((b_o ^ b_i) == {WIDTH{1'b1}}); // R2
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_msb_in_o,
  output logic             co_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic cin_here, cout_here, sum_here;
    if (i == 0) begin : g_first
      assign cin_here = ci_i;
    end else begin : g_next
      assign cin_here = g_stage[i-1].cout_here;
    end
    addsub_full_adder u_fa (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .ci_i(cin_here),
      .s_o (sum_here),
      .co_o(cout_here)
    );
    assign s_o[i] = sum_here;
  end

  assign c_msb_in_o = g_stage[WIDTH-1].cin_here;
  assign co_o       = g_stage[WIDTH-1].cout_here;

  always_comb begin
    AST_CHAIN_TOTAL: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, ci_i})); // R1
  end
endmodule

// File: rtl/gated_addsub.sv
module gated_addsub
  import gated_addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             add_sel,
  input  logic             sub_sel,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             ovf_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_gated;
  logic             cin0;
  logic             c_into_msb;

  addsub_operand_gate #(.WIDTH(WIDTH)) u_gate (
    .b_i        (op_b),
    .pass_true_i(add_sel),
    .pass_inv_i (sub_sel),
    .b_o        (b_gated),
    .cin_o      (cin0)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_chain (
    .x_i       (op_a),
    .y_i       (b_gated),
    .ci_i      (cin0),
    .s_o       (sum_out),
    .c_msb_in_o(c_into_msb),
    .co_o      (carry_out)
  );

  assign ovf_out = c_into_msb ^ carry_out;

  // Checks against arithmetic written from the operation, not from the gates
  mode_e            mode;
  logic [WIDTH:0]   ref_add;
  logic [WIDTH-1:0] ref_diff;
  assign mode     = mode_e'({add_sel, sub_sel});
  assign ref_add  = {1'b0, op_a} + {1'b0, op_b};
  assign ref_diff = op_a - op_b;

  always_comb begin
    unique case (mode)
      MODE_ADD: begin
        AST_ADD_RESULT: assert ({carry_out, sum_out} == ref_add); // R1
        AST_ADD_OVF: assert (ovf_out == ((op_a[MSB] == op_b[MSB]) && (sum_out[MSB] != op_a[MSB]))); // R3
      end
      MODE_SUB: begin
        AST_SUB_RESULT: assert (sum_out == ref_diff && carry_out == (op_a >= op_b)); // R2
        AST_SUB_OVF: assert (ovf_out == ((op_a[MSB] != op_b[MSB]) && (sum_out[MSB] != op_a[MSB]))); // R3
        if (!ovf_out) AST_SUB_SIGN: assert (sum_out[MSB] == ($signed(op_a) < $signed(op_b))); // R8
      end
      MODE_IDLE: begin
        AST_IDLE_PASS: assert (sum_out == op_a && !carry_out && !ovf_out); // R4
      end
      MODE_BOTH: begin
        AST_BOTH_PASS: assert (sum_out == op_a && carry_out && !ovf_out); // R5
      end
      default: ;
    endcase
  end
endmodule

// File: tb/gated_addsub_test.sv
`timescale 1ns/1ps
module gated_addsub_test;
  logic       clk = 1'b0;
  logic [3:0] op_a = '0, op_b = '0;
  logic       add_sel = 1'b0, sub_sel = 1'b0;
  logic [3:0] sum_out;
  logic       carry_out, ovf_out;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gated_addsub uut (
    .op_a(op_a), .op_b(op_b), .add_sel(add_sel), .sub_sel(sub_sel),
    .sum_out(sum_out), .carry_out(carry_out), .ovf_out(ovf_out)
  );

  // Expected value from the requirement text, using integer arithmetic
  function automatic logic [5:0] expect_of(input logic [3:0] a, input logic [3:0] b,
                                           input logic ad, input logic sb);
    int sa, sbv, sres, ures;
    logic [3:0] r; logic c, v;
    sa = $signed(a); sbv = $signed(b);
    if (ad && !sb) begin
      ures = int'(a) + int'(b); r = ures[3:0]; c = ures[4];
      sres = sa + sbv; v = (sres > 7) || (sres < -8);
    end else if (sb && !ad) begin
      ures = int'(a) - int'(b); r = ures[3:0]; c = (a >= b);
      sres = sa - sbv; v = (sres > 7) || (sres < -8);
    end else begin
      r = a; c = ad; v = 1'b0;
    end
    return {r, c, v};
  endfunction

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic ad,
                       input logic sb, input string tag);
    logic [5:0] exp_v, got;
    @(posedge clk);
    op_a = a; op_b = b; add_sel = ad; sub_sel = sb;
    @(negedge clk);
    exp_v = expect_of(a, b, ad, sb);
    got   = {sum_out, carry_out, ovf_out};
    n_cmp++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s a=%b b=%b add=%b sub=%b : got sum=%b c=%b v=%b, expected sum=%b c=%b v=%b",
               tag, a, b, ad, sb, got[5:2], got[1], got[0], exp_v[5:2], exp_v[1], exp_v[0]);
    end
  endtask

  initial begin
    void'($urandom(32'd2411));
    // Rest state with both lines low: R4
    apply(4'd0, 4'd0, 1'b0, 1'b0, "R4 rest");
    // Worked cases
    apply(4'b0100, 4'b0110, 1'b0, 1'b1, "R6 4-6");
    apply(4'b1101, 4'b0110, 1'b1, 1'b0, "R7 -3+6");
    // Overflow corners
    apply(4'b0111, 4'b0001, 1'b1, 1'b0, "R3 7+1");
    apply(4'b1000, 4'b1111, 1'b1, 1'b0, "R3 -8+-1");
    apply(4'b1000, 4'b0001, 1'b0, 1'b1, "R3 -8-1");
    apply(4'b0111, 4'b1111, 1'b0, 1'b1, "R3 7-(-1)");
    apply(4'b0000, 4'b1000, 1'b0, 1'b1, "R3 0-(-8)");
    apply(4'b1111, 4'b1111, 1'b1, 1'b0, "R1 -1+-1");
    apply(4'b0011, 4'b0011, 1'b0, 1'b1, "R2 equal");
    apply(4'b0010, 4'b0101, 1'b0, 1'b1, "R8 sign");
    apply(4'b1010, 4'b0101, 1'b0, 1'b0, "R4 idle");
    apply(4'b1010, 4'b0101, 1'b1, 1'b1, "R5 both");
    apply(4'b0000, 4'b0000, 1'b1, 1'b1, "R5 both zero");
    apply(4'b1111, 4'b1111, 1'b1, 1'b1, "R5 both ones");
    // Random mix over all four modes
    for (int k = 0; k < 600; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      case (m)
        2'b10:   apply(4'($urandom), 4'($urandom), 1'b1, 1'b0, "R1 random add");
        2'b01:   apply(4'($urandom), 4'($urandom), 1'b0, 1'b1, "R2 random sub");
        2'b00:   apply(4'($urandom), 4'($urandom), 1'b0, 1'b0, "R4 random idle");
        default: apply(4'($urandom), 4'($urandom), 1'b1, 1'b1, "R5 random both");
      endcase
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule